// File: doc/BRIEF.md
# Page Attribute Memory Type Combiner

This block holds a 64-bit page attribute register made of eight byte-wide entries, each naming a memory type. For every lookup it takes the flag word of a 4 KB leaf page-table entry and a memory type that an address-range unit has already worked out. Three of the page flags form a 3-bit entry index. The type stored in the selected entry is then merged with the range type through a fixed precedence table, and the block returns the effective memory type one cycle later.

Software updates the attribute register through a 64-bit write port. A write is taken only when every byte holds a legal type code. A write that is refused leaves the register unchanged and raises an error flag for one cycle. Page walking and the range type calculation stay outside the block.

Top module: `pamt_combiner`

## Requirements
- R1: After reset the eight entries, from index 0 to index 7, hold WB, WT, UC-minus, UC, WB, WT, UC-minus, UC. `out_valid` and `wr_err` are low.
- R2: The entry index is {flag bit 7, flag bit 4, flag bit 3}. Flag bit 3 is the write-through flag and gives the index LSB. Flag bit 4 is the cache-disable flag and gives index bit 1. Flag bit 7 is the page attribute flag and gives the index MSB. No other flag bit affects the result.
- R3: Entry n is bits [8n+7:8n] of the register. Its low three bits give the page type. Type codes are UC=0, WC=1, WT=4, WP=5, WB=6 and UC-minus=7. Codes 2 and 3 are reserved.
- R4: With range type UC, UC and WC pages pass through unchanged. WT, WP, WB and UC-minus pages give UC.
- R5: With range type WC, UC gives UC and WC gives WC. WT and WP give UC. WB and UC-minus give WC.
- R6: With range type WT, UC, WC, WT and WP pass through. WB gives WT and UC-minus gives UC.
- R7: With range type WP, UC, WC, WT and WP pass through. WB gives WP and UC-minus gives WC.
- R8: With range type WB, UC, WC, WT, WP and WB pass through. UC-minus gives UC.
- R9: A range type of 2, 3 or 7 gives 2 for every page type. A reserved page type gives 2 under any range type.
- R10: A write whose eight bytes are all in {0,1,4,5,6,7} replaces the register. Lookups presented from the next cycle on use the new value.
- R11: A write with any byte outside {0,1,4,5,6,7} leaves the register unchanged. It raises `wr_err` for exactly the one cycle after the write.
- R12: `out_valid` is high in exactly the cycle after a cycle with `lk_valid` high. `eff_type` then carries the result for that lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Attribute register write strobe |
| wr_data | input | 64 | Proposed attribute register value |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| lk_valid | input | 1 | Lookup strobe |
| pte_flags | input | 12 | Leaf page-table entry flag word |
| range_type | input | 3 | Memory type from the address-range unit |
| out_valid | output | 1 | Effective type valid |
| eff_type | output | 3 | Effective memory type |

## Verification
Each lookup result appears one cycle after its strobe, and `wr_err` appears one cycle after the write that caused it. A write takes effect for any lookup that follows it. The driver applies inputs on the falling edge and pushes the expected type into a queue for each lookup. The monitor pops one entry on each falling edge where `out_valid` is high, which is exactly one rising edge after the strobe. The write task samples `wr_err` on the first falling edge after the write and again one edge later to confirm that it is a single-cycle pulse.

// File: rtl/pamt_pkg.sv
`timescale 1ns/1ps
package pamt_pkg;

    localparam int ENTRIES = 8;
    localparam int ENTRY_W = 8;
    localparam int REG_W   = ENTRIES * ENTRY_W;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int TYPE_W  = 3;

    typedef enum logic [TYPE_W-1:0] {
        MT_UC   = 3'd0,
        MT_WC   = 3'd1,
        MT_RSV2 = 3'd2,
        MT_RSV3 = 3'd3,
        MT_WT   = 3'd4,
        MT_WP   = 3'd5,
        MT_WB   = 3'd6,
        MT_UCM  = 3'd7
    } mtype_e;

    typedef logic [ENTRY_W-1:0]               entry_t;
    typedef logic [ENTRIES-1:0][ENTRY_W-1:0]  attr_t;

    // index 0..7: WB, WT, UC-minus, UC, repeated
    localparam attr_t ATTR_RESET = 64'h0007_0406_0007_0406;

    typedef struct packed {
        logic   valid;
        mtype_e rng;
        mtype_e pg;
    } lookup_t;

    typedef struct packed {
        logic   valid;
        mtype_e typ;
    } result_t;

    function automatic logic byte_legal(entry_t b);
        return (b == 8'd0) || (b == 8'd1) || (b == 8'd4) ||
               (b == 8'd5) || (b == 8'd6) || (b == 8'd7);
    endfunction

    function automatic logic attr_legal(attr_t a);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < ENTRIES; i++) begin
            ok = ok & byte_legal(a[i]);
        end
        return ok;
    endfunction

    function automatic logic is_reserved(mtype_e t);
        return (t == MT_RSV2) || (t == MT_RSV3);
    endfunction

    // Precedence between the range type and the page type
    function automatic mtype_e resolve(mtype_e rng, mtype_e pg);
        mtype_e r;
        if (is_reserved(rng) || rng == MT_UCM || is_reserved(pg)) begin
            r = MT_RSV2;
        end else if (pg == MT_UC || pg == MT_WC) begin
            r = pg;
        end else begin
            unique case (rng)
                MT_UC:   r = MT_UC;
                MT_WC:   r = (pg == MT_WB || pg == MT_UCM) ? MT_WC : MT_UC;
                MT_WT:   r = (pg == MT_UCM) ? MT_UC :
                             (pg == MT_WB)  ? MT_WT : pg;
                MT_WP:   r = (pg == MT_UCM) ? MT_WC :
                             (pg == MT_WB)  ? MT_WP : pg;
                MT_WB:   r = (pg == MT_UCM) ? MT_UC : pg;
                default: r = MT_RSV2;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/pamt_attr_reg.sv
`timescale 1ns/1ps
module pamt_attr_reg
    import pamt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  attr_t wr_data,
    output attr_t attr_q,
    output logic  wr_err
);

    logic [ENTRIES-1:0] byte_ok;
    logic               all_ok;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
            assign byte_ok[g] = byte_legal(wr_data[g]);
        end
    endgenerate

    assign all_ok = &byte_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            attr_q <= ATTR_RESET;
            wr_err <= 1'b0;
        end else begin
            wr_err <= wr_en & ~all_ok;
            if (wr_en && all_ok) begin
                attr_q <= wr_data;
            end
        end
    end

    a_r11_err_needs_write: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(wr_en));

    a_r11_hold_on_reject: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $stable(attr_q));

    a_r10_contents_legal: assert property (@(posedge clk) disable iff (rst)
        attr_legal(attr_q));

endmodule

// File: rtl/pamt_index.sv
`timescale 1ns/1ps
module pamt_index
    import pamt_pkg::*;
#(
    parameter int PTE_W   = 12,
    parameter int PWT_POS = 3,
    parameter int PCD_POS = 4,
    parameter int PAT_POS = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [PTE_W-1:0] pte_flags,
    input  attr_t            attr_q,
    output mtype_e           page_type
);

    logic [IDX_W-1:0] idx;
    entry_t           sel;

    // R2: index bits from the three page flags
    assign idx = {pte_flags[PAT_POS], pte_flags[PCD_POS], pte_flags[PWT_POS]};
    // R3: byte n of the register
    assign sel       = attr_q[idx];
    assign page_type = mtype_e'(sel[TYPE_W-1:0]);

    a_r2_flags_known: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> !$isunknown(pte_flags));

    a_r3_entry_legal: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> byte_legal(sel));

endmodule

// File: rtl/pamt_resolve.sv
`timescale 1ns/1ps
module pamt_resolve
    import pamt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  lookup_t lk,
    output result_t res
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '{valid: 1'b0, typ: MT_UC};
        end else begin
            res.valid <= lk.valid;
            if (lk.valid) begin
                res.typ <= resolve(lk.rng, lk.pg);
            end
        end
    end

    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        lk.valid |=> res.valid);

    a_r12_idle_low: assert property (@(posedge clk) disable iff (rst)
        !lk.valid |=> !res.valid);

    a_r9_reserved_range: assert property (@(posedge clk) disable iff (rst)
        (lk.valid && (is_reserved(lk.rng) || lk.rng == MT_UCM)) |=> res.typ == MT_RSV2);

    a_r4_uc_range_uncached: assert property (@(posedge clk) disable iff (rst)
        (lk.valid && lk.rng == MT_UC) |=> (res.typ == MT_UC || res.typ == MT_WC));

    a_r8_no_minus_out: assert property (@(posedge clk) disable iff (rst)
        res.valid |-> (res.typ != MT_UCM && res.typ != MT_RSV3));

endmodule

// File: rtl/pamt_combiner.sv
`timescale 1ns/1ps
module pamt_combiner
    import pamt_pkg::*;
#(
    parameter int PTE_W   = 12,
    parameter int PWT_POS = 3,
    parameter int PCD_POS = 4,
    parameter int PAT_POS = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic                wr_err,
    input  logic                lk_valid,
    input  logic [PTE_W-1:0]    pte_flags,
    input  logic [TYPE_W-1:0]   range_type,
    output logic                out_valid,
    output logic [TYPE_W-1:0]   eff_type
);

    attr_t   attr_q;
    mtype_e  page_type;
    lookup_t lk;
    result_t res;

    pamt_attr_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (attr_t'(wr_data)),
        .attr_q  (attr_q),
        .wr_err  (wr_err)
    );

    pamt_index #(
        .PTE_W   (PTE_W),
        .PWT_POS (PWT_POS),
        .PCD_POS (PCD_POS),
        .PAT_POS (PAT_POS)
    ) u_idx (
        .clk       (clk),
        .rst       (rst),
        .lk_valid  (lk_valid),
        .pte_flags (pte_flags),
        .attr_q    (attr_q),
        .page_type (page_type)
    );

    assign lk = '{valid: lk_valid, rng: mtype_e'(range_type), pg: page_type};

    pamt_resolve u_res (
        .clk (clk),
        .rst (rst),
        .lk  (lk),
        .res (res)
    );

    assign out_valid = res.valid;
    assign eff_type  = res.typ;

endmodule

// File: tb/test_pamt_combiner.sv
`timescale 1ns/1ps
module test_pamt_combiner;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        wr_err;
    logic        lk_valid = 1'b0;
    logic [11:0] pte_flags = '0;
    logic [2:0]  range_type = '0;
    logic        out_valid;
    logic [2:0]  eff_type;

    always #4 clk = ~clk;

    pamt_combiner i_pamt_combiner (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
        .lk_valid(lk_valid), .pte_flags(pte_flags), .range_type(range_type),
        .out_valid(out_valid), .eff_type(eff_type)
    );

    typedef struct { int exp; string tag; } item_t;
    item_t       sbq[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [63:0] shadow;
    bit          done = 0;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected table, rows = range type, columns = page type
    function automatic int model(int r, int p);
        int row[8];
        case (r)
            0: row = '{0, 1, 2, 2, 0, 0, 0, 0};
            1: row = '{0, 1, 2, 2, 0, 0, 1, 1};
            4: row = '{0, 1, 2, 2, 4, 5, 4, 0};
            5: row = '{0, 1, 2, 2, 4, 5, 5, 1};
            6: row = '{0, 1, 2, 2, 4, 5, 6, 0};
            default: row = '{2, 2, 2, 2, 2, 2, 2, 2};
        endcase
        return row[p];
    endfunction

    task automatic lookup(int idx, int r, logic [11:0] noise, string tag);
        logic [11:0] f;
        int pg;
        f = noise & ~12'h098;
        f[3] = idx[0];
        f[4] = idx[1];
        f[7] = idx[2];
        pg = int'(shadow[8*idx +: 3]);
        @(negedge clk);
        lk_valid = 1'b1;
        pte_flags = f;
        range_type = 3'(r);
        sbq.push_back('{model(r, pg), tag});
    endtask

    task automatic idle();
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic write(logic [63:0] d, bit ok, string tag);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(tag, int'(wr_err), ok ? 0 : 1);
        if (ok) shadow = d;
        @(negedge clk);
        check({tag, " single pulse"}, int'(wr_err), 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: one result per cycle with out_valid high
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (sbq.size() == 0) begin
                    check("R12 unexpected out_valid", 1, 0);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    check(it.tag, int'(eff_type), it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        string rtag[8];
        rtag = '{"R4 range UC", "R5 range WC", "R9 reserved range 2", "R9 reserved range 3",
                 "R6 range WT", "R7 range WP", "R8 range WB", "R9 reserved range 7"};
        shadow = 64'h0007_0406_0007_0406;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset out_valid", int'(out_valid), 0);
        check("R1 reset wr_err", int'(wr_err), 0);

        // R1: reset entries seen through WB and WP ranges
        for (int i = 0; i < 8; i++) lookup(i, 6, 12'h000, "R1 reset entry range WB");
        for (int i = 0; i < 8; i++) lookup(i, 5, 12'h000, "R1 reset entry range WP");
        idle();

        // R10: legal write with distinct bytes
        write(64'h0106_0706_0504_0100, 1'b1, "R10 legal write");
        for (int i = 0; i < 8; i++) lookup(i, 6, 12'h000, "R3 entry slice");
        // R2: unrelated flag bits set
        for (int i = 0; i < 8; i++) lookup(i, 5, 12'hF67, "R2 index with noise flags");
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < 8; i++) lookup(i, r, 12'h000, rtag[r]);
        idle();

        // R11: rejected writes
        write(64'h0106_0206_0504_0100, 1'b0, "R11 reserved byte rejected");
        write(64'h0106_0706_0504_0110, 1'b0, "R11 out-of-range byte rejected");
        write(64'h0306_0706_0504_0100, 1'b0, "R11 code 3 rejected");
        for (int i = 0; i < 8; i++) lookup(i, 4, 12'h000, "R11 register unchanged");
        idle();

        // R10: second legal write takes effect
        write(64'h0504_0100_0706_0504, 1'b1, "R10 second legal write");
        for (int i = 0; i < 8; i++) lookup(i, 6, 12'hA00, "R10 new value used");
        idle();

        repeat (2) @(negedge clk);
        check("R12 out_valid low when idle", int'(out_valid), 0);
        check("R12 all results delivered", sbq.size(), 0);
        done = 1;
        finish_run();
    end

endmodule